// File: doc/BRIEF.md
# Master-Port Address Decoder with Access Guard

This block sits in the master stage of a multi-master AHB interconnect. Each master has one instance. During the address phase it turns the transfer address into a one-hot select for one of `NS` slave ports. Each slave port owns an aligned, power-of-two address window. Before a select is raised, the block checks the access against three rules. The first is a per-master rights table that gives each slave port none, read-only or read-write rights. The second is a master-enable input that bars all writes when it is low. The third is a protected address window that refuses writes from the instance built as the fabric-side master.

A refused access never reaches a slave. The block answers it as the default slave would, with the two-cycle AHB ERROR response. It also sets a sticky violation flag, and software clears that flag with a write-one-to-clear pulse. The surrounding interconnect routes `rsp_hready` and `rsp_hresp` back to the master while no slave is selected. It feeds the shared bus HREADY back in on `hready_in`.

Top module: `ahb_mstage_guard`

## Requirements
- R1: For an active transfer (`htrans` 2'b10 NONSEQ or 2'b11 SEQ) that is allowed, `slave_sel` has exactly the bit of the slave whose window holds `haddr`, in the same cycle. Bit i is slave i, and a window is `SLV_BASE[i]` aligned to 2^`SLV_LOG2[i]` bytes.
- R2: An IDLE (2'b00) or BUSY (2'b01) transfer raises no select and never starts an error, whatever its address, write flag or enable. The response stays zero-wait OKAY (`rsp_hready`=1, `rsp_hresp`=0).
- R3: A write to a slave whose 2-bit rights code is read-only (2'b01) is refused. Bit 1 of that code grants writing and bit 0 grants reading. Codes 2'b00 and 2'b10 both mean no access, and 2'b11 means read-write.
- R4: A read or a write to an address outside every slave window is refused.
- R5: When `IS_FABRIC` is set, a write inside the protected window (`PROT_BASE` aligned to 2^`PROT_LOG2` bytes) is refused. A read there follows the normal rules.
- R6: While `mst_en` is low, every write is refused. Reads are still judged only by the window and rights rules.
- R7: A read or a write to a slave whose rights code means no access is refused.
- R8: A refused active transfer is accepted only when `hready_in` is high. On the next cycle the response is `rsp_hready`=0 and `rsp_hresp`=1. On the cycle after that it is `rsp_hready`=1 and `rsp_hresp`=1. It then returns to OKAY unless a new refused transfer was accepted in that second cycle. Transfers presented during the first error cycle are not accepted.
- R9: `err_flag` rises in the cycle after a refused transfer is accepted. It stays high until an `err_clr` pulse arrives in a cycle with no new refusal; a refusal in the same cycle as `err_clr` wins.
- R10: After a synchronous reset (`rst_n` low at a clock edge) `err_flag` is 0 and the response is zero-wait OKAY.
- R11: A refused transfer shown while `hready_in` is low causes no error response and does not set `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_en | input | 1 | Master enable; low bars all writes |
| haddr | input | AW | Transfer address |
| htrans | input | 2 | Transfer type (IDLE, BUSY, NONSEQ, SEQ) |
| hwrite | input | 1 | 1 = write, 0 = read |
| hready_in | input | 1 | Shared bus ready; high means the address phase is taken |
| err_clr | input | 1 | Write-one-to-clear pulse for the violation flag |
| slave_sel | output | NS | One-hot slave port select |
| rsp_hready | output | 1 | Ready from the built-in error responder |
| rsp_hresp | output | 1 | Response from the built-in error responder (1 = ERROR) |
| err_flag | output | 1 | Sticky violation flag |

## Verification
The bench builds a 16-bit address space with four 4 KiB windows at 0x0000, 0x1000, 0x2000 and 0x4000, which leaves a hole at 0x3000 and everything above 0x4FFF unmapped. The rights are read-write, read-only, no-access using the 2'b10 spelling, and read-write. This puts every rights code and both kinds of unmapped address within reach. The instance is built as the fabric master, with a 2 KiB protected window inside the last slave. That allows a refused write and an allowed read at the same address. The enable, hready and clear inputs are driven in patterns that reach the back-to-back error path and the set-beats-clear collision.

// File: rtl/ahb_guard_pkg.sv
// Shared encodings for the master-stage access guard.
// Assumes AHB transfer-type coding; rights codes are two bits per slave.
package ahb_guard_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_t;

    // bit 1 grants write, bit 0 grants read; write without read counts as none
    typedef enum logic [1:0] {
        RIGHTS_NONE    = 2'b00,
        RIGHTS_RO      = 2'b01,
        RIGHTS_NONE_WO = 2'b10,
        RIGHTS_RW      = 2'b11
    } rights_t;

    typedef enum logic [1:0] {
        RSP_OKAY     = 2'b00,
        RSP_ERR_WAIT = 2'b01,
        RSP_ERR_LAST = 2'b10
    } rsp_state_t;

endpackage

// File: rtl/ahb_guard_decode.sv
// Address decoder: matches the address against NS aligned power-of-two
// windows and returns a one-hot hit plus its index.
// Assumes windows do not overlap; if they do, the lowest index wins.
module ahb_guard_decode #(
    parameter int              AW       = 32,
    parameter int              NS       = 4,
    parameter int              IW       = 2,
    parameter logic [NS*AW-1:0] SLV_BASE = '0,
    parameter logic [NS*8-1:0]  SLV_LOG2 = '0
) (
    input  logic [AW-1:0] haddr,
    output logic [NS-1:0] hit,
    output logic          any_hit,
    output logic [IW-1:0] hit_idx
);

    logic [NS-1:0] raw;

    // per-window compare on the address bits above the window size
    for (genvar g = 0; g < NS; g++) begin : g_win
        localparam logic [AW-1:0] BASE = SLV_BASE[g*AW +: AW];
        localparam int            SZ   = int'(SLV_LOG2[g*8 +: 8]);
        localparam logic [AW-1:0] MASK = ~((AW'(1) << SZ) - AW'(1));
        assign raw[g] = ((haddr ^ BASE) & MASK) == '0;
    end

    // priority pick so the hit stays one-hot even on overlapping windows
    always_comb begin
        hit     = '0;
        hit_idx = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (raw[i]) begin
                hit     = '0;
                hit[i]  = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end

    assign any_hit = |raw;

endmodule

// File: rtl/ahb_guard_check.sv
// Access checker: applies the rights table, the master enable and the
// protected window to a decoded transfer and reports whether it is allowed.
// Assumes hit_idx is only meaningful when any_hit is high.
module ahb_guard_check
    import ahb_guard_pkg::*;
#(
    parameter int              AW        = 32,
    parameter int              NS        = 4,
    parameter int              IW        = 2,
    parameter logic [NS*2-1:0] PERM      = '1,
    parameter bit              IS_FABRIC = 1'b0,
    parameter logic [AW-1:0]   PROT_BASE = '0,
    parameter int              PROT_LOG2 = 12
) (
    input  logic [AW-1:0] haddr,
    input  logic          hwrite,
    input  logic          mst_en,
    input  logic          any_hit,
    input  logic [IW-1:0] hit_idx,
    output logic          allowed
);

    localparam logic [AW-1:0] PMASK = ~((AW'(1) << PROT_LOG2) - AW'(1));

    rights_t tab [NS];
    rights_t rights;
    logic    in_prot;
    logic    rd_ok;
    logic    wr_ok;

    // rights table unpacked from the parameter vector
    for (genvar g = 0; g < NS; g++) begin : g_tab
        assign tab[g] = rights_t'(PERM[g*2 +: 2]);
    end

    assign rights  = tab[hit_idx];
    assign in_prot = IS_FABRIC && (((haddr ^ PROT_BASE) & PMASK) == '0);

    // read and write legality, then choose by direction
    always_comb begin
        rd_ok   = any_hit && (rights == RIGHTS_RO || rights == RIGHTS_RW);
        wr_ok   = any_hit && (rights == RIGHTS_RW) && mst_en && !in_prot;
        allowed = hwrite ? wr_ok : rd_ok;
    end

endmodule

// File: rtl/ahb_guard_resp.sv
// Error responder and sticky flag: runs the two-cycle ERROR response for an
// accepted violation and holds the flag until a clear pulse.
// Assumes the caller never reports a violation while err_wait is high.
module ahb_guard_resp
    import ahb_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic viol_take,
    input  logic err_clr,
    output logic err_wait,
    output logic rsp_hready,
    output logic rsp_hresp,
    output logic err_flag
);

    rsp_state_t st;

    // response sequencer: wait cycle, final cycle, back to OKAY
    always_ff @(posedge clk) begin
        if (!rst_n)                 st <= RSP_OKAY;
        else if (viol_take)         st <= RSP_ERR_WAIT;
        else if (st == RSP_ERR_WAIT) st <= RSP_ERR_LAST;
        else                        st <= RSP_OKAY;
    end

    // sticky flag, a new violation beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)         err_flag <= 1'b0;
        else if (viol_take) err_flag <= 1'b1;
        else if (err_clr)   err_flag <= 1'b0;
    end

    assign err_wait   = (st == RSP_ERR_WAIT);
    assign rsp_hready = (st != RSP_ERR_WAIT);
    assign rsp_hresp  = (st != RSP_OKAY);

endmodule

// File: rtl/ahb_mstage_guard.sv
// Master-stage decoder with access guard: one instance per master. Selects
// the slave port for allowed transfers and answers refused ones itself.
// Assumes the interconnect returns rsp_* to the master when no slave is
// selected, and that hready_in is the shared bus ready.
module ahb_mstage_guard
    import ahb_guard_pkg::*;
#(
    parameter int               AW        = 32,
    parameter int               NS        = 4,
    parameter logic [NS*AW-1:0] SLV_BASE  = {32'h4000_0000, 32'h2002_0000,
                                             32'h2001_0000, 32'h2000_0000},
    parameter logic [NS*8-1:0]  SLV_LOG2  = {8'd20, 8'd16, 8'd16, 8'd16},
    parameter logic [NS*2-1:0]  PERM      = '1,
    parameter bit               IS_FABRIC = 1'b0,
    parameter logic [AW-1:0]    PROT_BASE = 32'h2000_8000,
    parameter int               PROT_LOG2 = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mst_en,
    input  logic [AW-1:0] haddr,
    input  logic [1:0]    htrans,
    input  logic          hwrite,
    input  logic          hready_in,
    input  logic          err_clr,
    output logic [NS-1:0] slave_sel,
    output logic          rsp_hready,
    output logic          rsp_hresp,
    output logic          err_flag
);

    localparam int IW = (NS > 1) ? $clog2(NS) : 1;

    logic [NS-1:0] hit;
    logic          any_hit;
    logic [IW-1:0] hit_idx;
    logic          allowed;
    logic          active;
    logic          err_wait;
    logic          viol_take;

    ahb_guard_decode #(
        .AW(AW), .NS(NS), .IW(IW), .SLV_BASE(SLV_BASE), .SLV_LOG2(SLV_LOG2)
    ) i_decode (
        .haddr(haddr), .hit(hit), .any_hit(any_hit), .hit_idx(hit_idx)
    );

    ahb_guard_check #(
        .AW(AW), .NS(NS), .IW(IW), .PERM(PERM), .IS_FABRIC(IS_FABRIC),
        .PROT_BASE(PROT_BASE), .PROT_LOG2(PROT_LOG2)
    ) i_check (
        .haddr(haddr), .hwrite(hwrite), .mst_en(mst_en),
        .any_hit(any_hit), .hit_idx(hit_idx), .allowed(allowed)
    );

    ahb_guard_resp i_resp (
        .clk(clk), .rst_n(rst_n), .viol_take(viol_take), .err_clr(err_clr),
        .err_wait(err_wait), .rsp_hready(rsp_hready), .rsp_hresp(rsp_hresp),
        .err_flag(err_flag)
    );

    // only NONSEQ and SEQ carry an address phase
    assign active = (trans_t'(htrans) == TR_NONSEQ) || (trans_t'(htrans) == TR_SEQ);

    // select only allowed active transfers
    assign slave_sel = (active && allowed) ? hit : '0;

    // a refusal is taken when the bus accepts the address phase
    assign viol_take = active && !allowed && hready_in && !err_wait;

endmodule

// File: rtl/ahb_mstage_guard_chk.sv
// Property checker for the access guard, bound to every instance.
module ahb_mstage_guard_chk #(
    parameter int NS = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mst_en,
    input logic [1:0]    htrans,
    input logic          hwrite,
    input logic          hready_in,
    input logic          err_clr,
    input logic [NS-1:0] slave_sel,
    input logic          rsp_hready,
    input logic          rsp_hresp,
    input logic          err_flag
);

    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slave_sel));

    p_idle_nosel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b00 || htrans == 2'b01) |-> slave_sel == '0);

    p_disabled_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mst_en && hwrite && htrans[1]) |-> slave_sel == '0);

    p_wait_is_error_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hready |-> rsp_hresp);

    p_wait_then_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hready |=> (rsp_hready && rsp_hresp));

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    p_no_take_unready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!hready_in && rsp_hready) |=> rsp_hready);

endmodule

bind ahb_mstage_guard ahb_mstage_guard_chk #(.NS(NS)) i_chk (
    .clk(clk), .rst_n(rst_n), .mst_en(mst_en), .htrans(htrans),
    .hwrite(hwrite), .hready_in(hready_in), .err_clr(err_clr),
    .slave_sel(slave_sel), .rsp_hready(rsp_hready), .rsp_hresp(rsp_hresp),
    .err_flag(err_flag)
);

// File: tb/test_ahb_mstage_guard.sv
`timescale 1ns/1ps
module test_ahb_mstage_guard;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mst_en;
    logic [15:0] haddr;
    logic [1:0]  htrans;
    logic        hwrite;
    logic        hready_in;
    logic        err_clr;
    logic [3:0]  slave_sel;
    logic        rsp_hready;
    logic        rsp_hresp;
    logic        err_flag;

    int checks = 0;
    int errors = 0;
    int mstate = 0;     // 0 okay, 1 error wait, 2 error last
    bit mflag  = 1'b0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ahb_mstage_guard #(
        .AW(16), .NS(4),
        .SLV_BASE(64'h4000_2000_1000_0000),
        .SLV_LOG2(32'h0C0C_0C0C),
        .PERM(8'b11_10_01_11),
        .IS_FABRIC(1'b1),
        .PROT_BASE(16'h4800),
        .PROT_LOG2(11)
    ) i_ahb_mstage_guard (
        .clk(clk), .rst_n(rst_n), .mst_en(mst_en), .haddr(haddr),
        .htrans(htrans), .hwrite(hwrite), .hready_in(hready_in),
        .err_clr(err_clr), .slave_sel(slave_sel), .rsp_hready(rsp_hready),
        .rsp_hresp(rsp_hresp), .err_flag(err_flag)
    );

    function automatic int slave_of(input logic [15:0] a);
        if (a < 16'h1000) return 0;
        if (a < 16'h2000) return 1;
        if (a < 16'h3000) return 2;
        if (a >= 16'h4000 && a < 16'h5000) return 3;
        return -1;
    endfunction

    function automatic bit is_legal(input bit en, input logic [15:0] a, input bit wr);
        int s = slave_of(a);
        int r;
        if (s < 0) return 1'b0;
        r = (s == 0) ? 3 : (s == 1) ? 1 : (s == 2) ? 2 : 3;
        if (!wr) return (r == 1 || r == 3);
        if (!en) return 1'b0;
        if (a >= 16'h4800 && a < 16'h5000) return 1'b0;
        return (r == 3);
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // one bus cycle: drive, check after settling, advance the model at the edge
    task automatic cyc(input bit en, input logic [15:0] a, input logic [1:0] tr,
                       input bit wr, input bit rdy, input bit clr, input string tag);
        bit act, legal, take;
        int exp_sel;
        mst_en = en; haddr = a; htrans = tr; hwrite = wr; hready_in = rdy; err_clr = clr;
        #1;
        act     = tr[1];
        legal   = is_legal(en, a, wr);
        exp_sel = (act && legal) ? (1 << slave_of(a)) : 0;
        cmp(tag, "slave_sel", int'(slave_sel), exp_sel);
        cmp(tag, "rsp_hready", int'(rsp_hready), (mstate != 1) ? 1 : 0);
        cmp(tag, "rsp_hresp", int'(rsp_hresp), (mstate != 0) ? 1 : 0);
        cmp(tag, "err_flag", int'(err_flag), int'(mflag));
        @(posedge clk);
        take = act && !legal && rdy && (mstate != 1);
        if (take) mstate = 1;
        else if (mstate == 1) mstate = 2;
        else mstate = 0;
        if (take) mflag = 1'b1;
        else if (clr) mflag = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mst_en = 1'b1; haddr = '0; htrans = 2'b00;
        hwrite = 1'b0; hready_in = 1'b1; err_clr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        cyc(1, 16'h0000, 2'b00, 0, 1, 0, "R10");
        // R1: allowed accesses to each mapped window
        cyc(1, 16'h0100, 2'b10, 0, 1, 0, "R1");
        cyc(1, 16'h0FFC, 2'b11, 1, 1, 0, "R1");
        cyc(1, 16'h1004, 2'b10, 0, 1, 0, "R1");
        cyc(1, 16'h4100, 2'b10, 1, 1, 0, "R1");
        cyc(1, 16'h47FC, 2'b11, 0, 1, 0, "R1");
        // R2: IDLE and BUSY to illegal targets
        cyc(0, 16'h3000, 2'b00, 1, 1, 0, "R2");
        cyc(1, 16'h1000, 2'b01, 1, 1, 0, "R2");
        cyc(1, 16'h2000, 2'b01, 0, 1, 0, "R2");
        // R3: write to read-only slave, then watch the two error cycles (R8)
        cyc(1, 16'h1004, 2'b10, 1, 1, 0, "R3");
        cyc(1, 16'h0000, 2'b00, 0, 0, 0, "R8");
        cyc(1, 16'h0000, 2'b00, 0, 1, 0, "R8");
        cyc(1, 16'h0000, 2'b00, 0, 1, 0, "R9");
        // R9: clear pulse
        cyc(1, 16'h0000, 2'b00, 0, 1, 1, "R9");
        cyc(1, 16'h0000, 2'b00, 0, 1, 0, "R9");
        // R4: unmapped read and write
        cyc(1, 16'h3000, 2'b10, 0, 1, 0, "R4");
        cyc(1, 16'h0000, 2'b00, 0, 0, 0, "R4");
        cyc(1, 16'h6000, 2'b10, 1, 1, 0, "R4");
        cyc(1, 16'h0000, 2'b00, 0, 0, 0, "R4");
        cyc(1, 16'h0000, 2'b00, 0, 1, 1, "R4");
        // R7: no-access slave, read and write
        cyc(1, 16'h2000, 2'b10, 0, 1, 0, "R7");
        cyc(1, 16'h0000, 2'b00, 0, 0, 0, "R7");
        cyc(1, 16'h2FF0, 2'b10, 1, 1, 1, "R7");
        cyc(1, 16'h0000, 2'b00, 0, 0, 0, "R7");
        cyc(1, 16'h0000, 2'b00, 0, 1, 1, "R7");
        // R5: protected window refuses write, allows read
        cyc(1, 16'h4900, 2'b10, 1, 1, 0, "R5");
        cyc(1, 16'h0000, 2'b00, 0, 0, 0, "R5");
        cyc(1, 16'h4900, 2'b10, 0, 1, 1, "R5");
        cyc(1, 16'h4FFC, 2'b11, 0, 1, 0, "R5");
        // R6: disabled master, write refused, read allowed
        cyc(0, 16'h0200, 2'b10, 1, 1, 0, "R6");
        cyc(0, 16'h0000, 2'b00, 0, 0, 0, "R6");
        cyc(0, 16'h0200, 2'b10, 0, 1, 1, "R6");
        cyc(0, 16'h1200, 2'b10, 0, 1, 0, "R6");
        // R11: refused transfer with hready_in low is not taken
        cyc(1, 16'h3000, 2'b10, 1, 0, 0, "R11");
        cyc(1, 16'h0000, 2'b00, 0, 1, 0, "R11");
        // R8: back-to-back, request in wait cycle ignored, in last cycle taken
        cyc(1, 16'h3000, 2'b10, 0, 1, 0, "R8");
        cyc(1, 16'h6000, 2'b10, 1, 1, 0, "R8");
        cyc(1, 16'h1000, 2'b10, 1, 1, 0, "R8");
        cyc(1, 16'h0000, 2'b00, 0, 0, 0, "R8");
        cyc(1, 16'h0000, 2'b00, 0, 1, 0, "R8");
        cyc(1, 16'h0000, 2'b00, 0, 1, 1, "R9");
        // R9: set beats a clear in the same cycle
        cyc(1, 16'h3000, 2'b10, 1, 1, 1, "R9");
        cyc(1, 16'h0000, 2'b00, 0, 0, 0, "R9");
        cyc(1, 16'h0000, 2'b00, 0, 1, 0, "R9");
        cyc(1, 16'h0000, 2'b00, 0, 1, 0, "R9");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule